// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Controller with Mirrored Snoop Tags

This block holds the tag side of a small direct-mapped cache. It keeps two copies of every tag entry. The processor copy answers lookups, and each answer comes one cycle after the request as hit or miss. The mirror copy watches write cycles on the system bus while a DMA device holds the bus grant. Each fill writes both copies in the same clock edge, so the two copies never differ.

While DMA owns the bus, the processor keeps making lookups and fills. The processor is stalled only when a DMA write lands on a line that is currently valid. When that happens, the controller clears the line in both copies and reports it on the invalidate outputs. It then holds the internal bus, keeping the processor stalled, and watches further DMA writes until the grant is withdrawn.

A build parameter selects a single-tag mode. In that mode the processor is stalled for the whole DMA tenure, whatever the addresses.

Top module: `snoop_dup_tag`

## Requirements
- R1: After reset no line is valid: every lookup misses, and `cpu_stall`, `ibus_own` and `inval_vld` are low.
- R2: A lookup uses index = address bits [8:1] and tag = address bits [17:9]. Bits [21:18] and bit 0 are ignored. The cycle after `cpu_req` is accepted, exactly one of `cpu_hit` and `cpu_miss` is high. `cpu_hit` is high only when the line is valid, the stored tag equals the address tag, and the stored parity is correct.
- R3: An accepted fill writes the tag and its even-parity bit into both copies and marks the line valid in both. The entry is seen by the next lookup and by the next snoop.
- R4: When `fill_perr_inj` is high during a fill, the inverted parity bit is stored. A later lookup of that valid line gives `cpu_miss` and a one-cycle `cpu_perr` pulse, whatever the tag.
- R5: A snoop hit is a cycle with `dma_grant`, `dma_wr` and a valid mirror entry whose tag equals the DMA address tag. The cycle after a snoop hit, `inval_vld` is high for one cycle and `inval_idx` holds the line index. The line is invalid in both copies from then on.
- R6: In the default mode, neither the grant alone nor DMA writes that miss stall the processor. Lookups and fills go on during DMA tenure.
- R7: `cpu_stall` and `ibus_own` rise the cycle after a snoop hit and stay high while `dma_grant` stays high. They fall one cycle after the first cycle in which `dma_grant` is sampled low.
- R8: While `cpu_stall` is high, `cpu_req` and `fill_en` are ignored: no hit or miss is reported and no entry changes.
- R9: With SINGLE_TAG set, `cpu_stall` equals `dma_grant` delayed by one cycle, for any addresses.
- R10: `dma_wr` without `dma_grant` never invalidates a line and never stalls the processor.
- R11: When a fill and a snoop hit target the same index in the same cycle, the invalidate wins and the line ends invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Lookup request |
| cpu_addr | input | 22 | Physical address to look up |
| cpu_hit | output | 1 | Lookup result: hit |
| cpu_miss | output | 1 | Lookup result: miss |
| cpu_perr | output | 1 | Parity error seen on lookup |
| fill_en | input | 1 | Write a tag entry |
| fill_addr | input | 22 | Physical address of the fill |
| fill_perr_inj | input | 1 | Store an inverted parity bit with this fill |
| dma_grant | input | 1 | System bus granted to DMA |
| dma_wr | input | 1 | DMA write cycle on the bus |
| dma_addr | input | 22 | DMA write address |
| cpu_stall | output | 1 | Processor stall |
| ibus_own | output | 1 | Controller holds the internal bus |
| inval_vld | output | 1 | Line invalidate pulse |
| inval_idx | output | 8 | Index of the invalidated line |

## Verification
The hardest case to reach is a fill and a snoop hit on the same index in the same cycle. This needs the line to be valid first, a DMA write with the matching tag, and a processor that is not yet stalled. The bench builds it directly: it refills a line, raises the grant, and drives the DMA write and a new fill to that index on the same edge. A random phase then packs addresses into a few indices and tags, which creates many more of these collisions. It also creates lookups on lines that were just invalidated and grants that drop in the same cycle as a hit.

// File: rtl/snoop_dup_tag.sv
module snoop_dup_tag #(
  parameter int PA_W       = 22,
  parameter int IDX_LSB    = 1,
  parameter int IDX_W      = 8,
  parameter int TAG_W      = 9,
  parameter bit SINGLE_TAG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic [PA_W-1:0]  cpu_addr,
  output logic             cpu_hit,
  output logic             cpu_miss,
  output logic             cpu_perr,
  input  logic             fill_en,
  input  logic [PA_W-1:0]  fill_addr,
  input  logic             fill_perr_inj,
  input  logic             dma_grant,
  input  logic             dma_wr,
  input  logic [PA_W-1:0]  dma_addr,
  output logic             cpu_stall,
  output logic             ibus_own,
  output logic             inval_vld,
  output logic [IDX_W-1:0] inval_idx
);

  localparam int LINES   = 1 << IDX_W;
  localparam int TAG_LSB = IDX_LSB + IDX_W;
  localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

  // entry = {parity, tag}; the whole entry XORs to zero when intact
  logic [TAG_W:0]   cpu_tags [LINES];
  logic [TAG_W:0]   dma_tags [LINES];
  logic [LINES-1:0] cpu_vld, dma_vld;
  logic             own_q;

  logic [IDX_W-1:0] c_idx, f_idx, d_idx;
  logic [TAG_W-1:0] c_tag, f_tag, d_tag;
  logic [TAG_W:0]   c_ent, d_ent, f_ent;
  logic             c_match, c_par_ok, snoop_hit, lk_go, fill_go;

  assign c_idx = cpu_addr[TAG_LSB-1:IDX_LSB];
  assign f_idx = fill_addr[TAG_LSB-1:IDX_LSB];
  assign d_idx = dma_addr[TAG_LSB-1:IDX_LSB];
  assign c_tag = cpu_addr[TAG_MSB:TAG_LSB];
  assign f_tag = fill_addr[TAG_MSB:TAG_LSB];
  assign d_tag = dma_addr[TAG_MSB:TAG_LSB];

  assign c_ent = cpu_tags[c_idx];
  assign d_ent = dma_tags[d_idx];
  assign f_ent = {(^f_tag) ^ fill_perr_inj, f_tag};

  assign c_par_ok  = ~(^c_ent);
  assign c_match   = cpu_vld[c_idx] && (c_ent[TAG_W-1:0] == c_tag);
  assign snoop_hit = dma_grant && dma_wr && dma_vld[d_idx] && (d_ent[TAG_W-1:0] == d_tag);
  assign lk_go     = cpu_req && !cpu_stall;
  assign fill_go   = fill_en && !cpu_stall && !(snoop_hit && (f_idx == d_idx));

  logic unused_bits;
  assign unused_bits = ^{cpu_addr[PA_W-1:TAG_MSB+1], cpu_addr[IDX_LSB-1:0],
                         fill_addr[PA_W-1:TAG_MSB+1], fill_addr[IDX_LSB-1:0],
                         dma_addr[PA_W-1:TAG_MSB+1], dma_addr[IDX_LSB-1:0],
                         d_ent[TAG_W]};

  always_ff @(posedge clk) begin
    if (fill_go) begin
      cpu_tags[f_idx] <= f_ent;
      dma_tags[f_idx] <= f_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_vld <= '0;
      dma_vld <= '0;
    end else begin
      if (fill_go) begin
        cpu_vld[f_idx] <= 1'b1;
        dma_vld[f_idx] <= 1'b1;
      end
      if (snoop_hit) begin
        cpu_vld[d_idx] <= 1'b0;
        dma_vld[d_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_hit  <= 1'b0;
      cpu_miss <= 1'b0;
      cpu_perr <= 1'b0;
    end else begin
      cpu_hit  <= lk_go && c_match && c_par_ok;
      cpu_miss <= lk_go && !(c_match && c_par_ok);
      cpu_perr <= lk_go && cpu_vld[c_idx] && !c_par_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q     <= 1'b0;
      inval_vld <= 1'b0;
      inval_idx <= '0;
    end else begin
      own_q     <= snoop_hit || (own_q && dma_grant);
      inval_vld <= snoop_hit;
      if (snoop_hit) inval_idx <= d_idx;
    end
  end

  assign ibus_own = own_q;

  generate
    if (SINGLE_TAG) begin : g_single
      logic grant_q;
      always_ff @(posedge clk) begin
        if (!rst_n) grant_q <= 1'b0;
        else        grant_q <= dma_grant;
      end
      assign cpu_stall = grant_q;
    end else begin : g_dual
      assign cpu_stall = own_q;
    end
  endgenerate

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_hit && cpu_miss));
  assert_result_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hit || cpu_miss) |-> $past(cpu_req));
  assert_perr_is_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_perr |-> cpu_miss);
  assert_inval_owns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inval_vld |-> ibus_own);
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_grant) |=> !cpu_stall);
  assert_stalled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_stall) |-> !(cpu_hit || cpu_miss));
  assert_stall_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> $past(dma_grant));

endmodule

// File: tb/tb_snoop_dup_tag.sv
`timescale 1ns/1ps
module tb_snoop_dup_tag;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, fill_en = 0, fill_perr_inj = 0, dma_grant = 0, dma_wr = 0;
  logic [21:0] cpu_addr = 0, fill_addr = 0, dma_addr = 0;
  logic cpu_hit, cpu_miss, cpu_perr, cpu_stall, ibus_own, inval_vld;
  logic [7:0] inval_idx;
  logic s_hit, s_miss, s_perr, s_stall, s_own, s_inv;
  logic [7:0] s_idx;

  always #2.5 clk = ~clk;

  snoop_dup_tag dut (.clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_hit(cpu_hit), .cpu_miss(cpu_miss), .cpu_perr(cpu_perr), .fill_en(fill_en),
    .fill_addr(fill_addr), .fill_perr_inj(fill_perr_inj), .dma_grant(dma_grant),
    .dma_wr(dma_wr), .dma_addr(dma_addr), .cpu_stall(cpu_stall), .ibus_own(ibus_own),
    .inval_vld(inval_vld), .inval_idx(inval_idx));

  snoop_dup_tag #(.SINGLE_TAG(1'b1)) dut1 (.clk(clk), .rst_n(rst_n), .cpu_req(cpu_req),
    .cpu_addr(cpu_addr), .cpu_hit(s_hit), .cpu_miss(s_miss), .cpu_perr(s_perr),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_perr_inj(fill_perr_inj),
    .dma_grant(dma_grant), .dma_wr(dma_wr), .dma_addr(dma_addr), .cpu_stall(s_stall),
    .ibus_own(s_own), .inval_vld(s_inv), .inval_idx(s_idx));

  int nchk = 0, nerr = 0;
  string cur_req = "R1";

  // reference model
  bit m_vld [256];
  int m_tag [256];
  bit m_pb  [256];
  bit m_hit, m_miss, m_perr, m_stall, m_own, m_inv, m_s1;
  int m_idx;

  always @(posedge clk) begin : model
    int ci, ct, fi, ft, di, dt;
    bit sn, good;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_vld[i] = 0;
      m_hit = 0; m_miss = 0; m_perr = 0; m_stall = 0; m_own = 0; m_inv = 0; m_s1 = 0; m_idx = 0;
    end else begin
      ci = (cpu_addr >> 1) % 256;  ct = (cpu_addr >> 9) % 512;
      fi = (fill_addr >> 1) % 256; ft = (fill_addr >> 9) % 512;
      di = (dma_addr >> 1) % 256;  dt = (dma_addr >> 9) % 512;
      sn = dma_grant && dma_wr && m_vld[di] && (m_tag[di] == dt);
      if (cpu_req && !m_stall) begin
        good = m_vld[ci] && (m_tag[ci] == ct) && !m_pb[ci];
        m_hit = good; m_miss = !good; m_perr = m_vld[ci] && m_pb[ci];
      end else begin
        m_hit = 0; m_miss = 0; m_perr = 0;
      end
      if (fill_en && !m_stall && !(sn && fi == di)) begin
        m_vld[fi] = 1; m_tag[fi] = ft; m_pb[fi] = fill_perr_inj;
      end
      if (sn) begin m_vld[di] = 0; m_idx = di; end
      m_inv = sn;
      m_own = sn || (m_own && dma_grant);
      m_stall = m_own;
      m_s1 = dma_grant;
    end
  end

  task automatic cmp(string sig, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("cpu_hit", cpu_hit, m_hit);
      cmp("cpu_miss", cpu_miss, m_miss);
      cmp("cpu_perr", cpu_perr, m_perr);
      cmp("cpu_stall", cpu_stall, m_stall);
      cmp("ibus_own", ibus_own, m_own);
      cmp("inval_vld", inval_vld, m_inv);
      if (m_inv) cmp("inval_idx", inval_idx, m_idx);
      cmp("single_stall_R9", s_stall, m_s1);
    end
  end

  function automatic logic [21:0] mk(int idx, int tag);
    return {$urandom_range(15, 0) & 4'hf, tag[8:0], idx[7:0], 1'($urandom_range(1, 0))};
  endfunction

  task automatic idle();
    cpu_req = 0; fill_en = 0; fill_perr_inj = 0; dma_wr = 0;
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic look(int idx, int tag);
    idle(); cpu_req = 1; cpu_addr = mk(idx, tag); step();
  endtask

  task automatic fill(int idx, int tag, bit inj);
    idle(); fill_en = 1; fill_addr = mk(idx, tag); fill_perr_inj = inj; step();
  endtask

  task automatic dwr(int idx, int tag);
    idle(); dma_wr = 1; dma_addr = mk(idx, tag); step();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired in %s", cur_req);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    cur_req = "R1";
    cmp("reset stall R1", cpu_stall, 0);
    cmp("reset own R1", ibus_own, 0);
    for (int i = 0; i < 6; i++) look(i * 40, 0);
    idle(); step();

    cur_req = "R3";
    for (int i = 0; i < 16; i++) fill(i, i * 31 + 5, 0);
    cur_req = "R2";
    for (int i = 0; i < 16; i++) look(i, i * 31 + 5);
    for (int i = 0; i < 16; i++) look(i, i * 31 + 6);
    look(200, 0);

    cur_req = "R4";
    fill(20, 77, 1);
    look(20, 77); look(20, 78);
    fill(20, 77, 0);
    look(20, 77);

    cur_req = "R6";
    dma_grant = 1;
    for (int i = 0; i < 20; i++) begin
      idle(); dma_wr = 1; dma_addr = mk(100 + i, 3);
      cpu_req = 1; cpu_addr = mk(i % 16, (i % 16) * 31 + 5); step();
    end
    fill(30, 9, 0); look(30, 9);
    dwr(30, 8);

    cur_req = "R5";
    dwr(3, 3 * 31 + 5);
    cur_req = "R8";
    idle(); cpu_req = 1; cpu_addr = mk(4, 4 * 31 + 5); fill_en = 1; fill_addr = mk(50, 1); step();
    idle(); step();
    cur_req = "R7";
    dwr(5, 5 * 31 + 5);
    dwr(6, 0);
    idle(); step(); step();
    dma_grant = 0; step(); step(); step();
    cur_req = "R5";
    look(3, 3 * 31 + 5); look(5, 5 * 31 + 5); look(50, 1); look(4, 4 * 31 + 5);

    cur_req = "R11";
    fill(7, 44, 0);
    dma_grant = 1;
    idle(); dma_wr = 1; dma_addr = mk(7, 44); fill_en = 1; fill_addr = mk(7, 45); step();
    idle(); step();
    dma_grant = 0; step(); step();
    look(7, 44); look(7, 45);

    cur_req = "R10";
    fill(8, 12, 0);
    dwr(8, 12); idle(); step();
    look(8, 12);

    cur_req = "R9";
    dma_grant = 1; idle(); step(); step(); step();
    dma_grant = 0; step(); step();

    cur_req = "R2";
    for (int n = 0; n < 4000; n++) begin
      cpu_req = ($urandom_range(3, 0) != 0);
      cpu_addr = mk($urandom_range(7, 0), $urandom_range(3, 0));
      fill_en = ($urandom_range(2, 0) == 0);
      fill_addr = mk($urandom_range(7, 0), $urandom_range(3, 0));
      fill_perr_inj = ($urandom_range(15, 0) == 0);
      if ($urandom_range(9, 0) == 0) dma_grant = ~dma_grant;
      dma_wr = ($urandom_range(1, 0) == 1);
      dma_addr = mk($urandom_range(7, 0), $urandom_range(3, 0));
      step();
    end
    idle(); dma_grant = 0; step(); step();
    summary();
  end
endmodule